// File: doc/BRIEF.md
# Trigger-Positioned Capture Buffer with Serial Access

This block is an on-chip logic analyzer. Every rising edge of a fast sampling clock presents a wide probe vector. While a capture is running, the block writes that vector into a circular sample buffer. When the single trigger bit is seen, the block keeps recording until the buffer holds a full window around the event, and then it freezes. The trigger sample lands at the index that software programmed. A second mode, continuous sampling, does not wait for a trigger: it records the next full window of samples that follow the arm command.

Software talks to the block through two pins, a software-driven clock and a serial configuration input, and it listens on one serial data output. Both software pins are resampled into the sampling clock domain. Every rising edge of the software clock does two things at once: it shifts one configuration bit in, and it moves the readout stream on by one bit.

Configuration bits are gathered into frames of AW+2 bits. A completed frame whose arm bit is set starts a new capture. The readout stream begins with a status header. Once a capture is complete, the stored samples follow the header, oldest first, and the stream then wraps back to the header. The buffer depth must be a power of two. The header width (2*AW+4) and the sample width must both be multiples of the frame length, so that readouts keep software aligned to frames.

Top module: `trig_logic_analyzer`

## Requirements
- R1: While a capture is running, the probe vector present at each rising edge of the sampling clock is stored. Successive samples go into successive buffer slots.
- R2: The configuration frame is AW+2 bits long (8 at the default depth of 64). It is taken from the serial input one bit per rising edge of the software clock, most significant bit first. Bit 7 is arm, bit 6 is mode (1 = continuous), and bits 5:0 are the trigger position. A completed frame with arm = 1 stores the mode and position and clears the done flag. It marks the block busy, discards any capture in progress, and restarts the readout stream at the header.
- R3: A completed frame with arm = 0 has no effect. The mode, position, capture state and header are left as they were.
- R4: In triggered mode, the first trigger seen while the block is armed marks the trigger sample. After it, exactly DEPTH-1-position further samples are taken, and then the capture freezes. In the readout, entry k holds the sample taken k-position cycles relative to the trigger, so the trigger sample sits at index position.
- R5: Both extreme trigger positions follow R4. At position 0 the trigger sample is the first entry and the window holds only later samples. At position DEPTH-1 the capture freezes on the trigger cycle itself.
- R6: A trigger can arrive before `position` samples have been taken since the arm command. It is still honoured. The header's valid count is then DEPTH minus the number of missing pre-trigger samples, and the invalid entries are the first ones in the readout.
- R7: In continuous mode, the trigger input is ignored. The block records the DEPTH consecutive samples that follow the arm command. The valid count is DEPTH, and the stored position field has no effect on placement.
- R8: The header is 16 bits at the default depth, sent most significant bit first. Its fields, from the top bit down, are: done (bit 15), busy (bit 14), the valid count (bits 13:7), mode (bit 6) and position (bits 5:0). Busy is 1 from the arm command until the capture freezes, and done is 1 from then on.
- R9: Readout is sent most significant bit first. If the header showed done, the header is followed by DEPTH sample words, oldest first, and the stream then returns to the header. If the header showed not done, the stream returns to the header straight away.
- R10: After reset, the header reads all zeros, the serial output is 0, and nothing is captured.
- R11: Once a capture has frozen, later probe activity does not change the stored samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low reset, synchronous to clk_i |
| probe_i | input | W | Observed signal vector |
| trig_i | input | 1 | Trigger event, sampled on clk_i |
| sw_clk_i | input | 1 | Software-driven serial clock |
| cfg_sdi_i | input | 1 | Serial configuration input |
| sdo_o | output | 1 | Serial readout of header and samples |

## Verification
The hardest case to reach from the ports is a trigger that fires before the pre-trigger region has filled. Arming takes place at an internal cycle the bench cannot see, so the exact fill level at the moment of the trigger is unknown. The stimulus handles this by holding the trigger high across the whole configuration frame. The trigger then lands on the very first armed cycle, where no earlier samples exist. The expected valid count and the run of consecutive probe values from the programmed index onward then follow directly from the chosen position. Random positions, including both extremes, exercise the window arithmetic for late triggers.

// File: rtl/la_pkg.sv
package la_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } la_state_e;

    function automatic int hdr_width(input int aw);
        return 2 * aw + 4;
    endfunction

endpackage

// File: rtl/la_sync_edge.sv
// Resamples the software clock and serial input into the sampling domain.
module la_sync_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic rise_o,
    output logic sdi_o
);
    typedef struct packed {
        logic c1;
        logic c2;
        logic c3;
        logic d1;
        logic d2;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.c1 = sclk_i;
        d.c2 = q.c1;
        d.c3 = q.c2;
        d.d1 = sdi_i;
        d.d2 = q.d1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign rise_o = q.c2 & ~q.c3;
    assign sdi_o  = q.d2;
endmodule

// File: rtl/la_sample_store.sv
// Flop-based sample buffer with one write port and an asynchronous read port.
module la_sample_store #(
    parameter int W     = 128,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/la_capture_ctrl.sv
// Capture state machine: write pointer, fill count, post-trigger count.
module la_capture_ctrl
    import la_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int HDR_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trig_i,
    input  logic             arm_i,
    input  logic             arm_mode_i,
    input  logic [AW-1:0]    arm_pos_i,
    output logic             we_o,
    output logic [AW-1:0]    waddr_o,
    output logic [AW-1:0]    start_o,
    output logic [HDR_W-1:0] hdr_o,
    output logic             done_o,
    output logic             busy_o,
    output logic [AW:0]      valid_o
);
    localparam logic [AW:0]   FULL = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        la_state_e     st;
        logic [AW-1:0] wptr;
        logic [AW:0]   fill;
        logic [AW-1:0] rem;
        logic [AW-1:0] start;
        logic [AW:0]   valid;
        logic          mode;
        logic [AW-1:0] pos;
    } ctl_t;

    ctl_t q, d;
    logic          we;
    logic [AW-1:0] epos;
    logic [AW:0]   pre;

    always_comb begin
        d    = q;
        we   = 1'b0;
        epos = q.mode ? '0 : q.pos;
        pre  = (q.fill < {1'b0, epos}) ? q.fill : {1'b0, epos};
        if (arm_i) begin
            d.st    = ST_ARMED;
            d.wptr  = '0;
            d.fill  = '0;
            d.rem   = '0;
            d.start = '0;
            d.valid = '0;
            d.mode  = arm_mode_i;
            d.pos   = arm_pos_i;
        end else begin
            unique case (q.st)
                ST_ARMED: begin
                    we     = 1'b1;
                    d.wptr = q.wptr + 1'b1;
                    if (q.fill != FULL) d.fill = q.fill + 1'b1;
                    if (q.mode || trig_i) begin
                        d.start = q.wptr - epos;
                        d.valid = FULL - {1'b0, epos} + pre;
                        d.rem   = LAST - epos;
                        d.st    = (epos == LAST) ? ST_DONE : ST_POST;
                    end
                end
                ST_POST: begin
                    we     = 1'b1;
                    d.wptr = q.wptr + 1'b1;
                    d.rem  = q.rem - 1'b1;
                    if (q.rem == AW'(1)) d.st = ST_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign we_o    = we;
    assign waddr_o = q.wptr;
    assign start_o = q.start;
    assign done_o  = (q.st == ST_DONE);
    assign busy_o  = (q.st == ST_ARMED) || (q.st == ST_POST);
    assign valid_o = q.valid;
    assign hdr_o   = {done_o, busy_o, q.valid, q.mode, q.pos};
endmodule

// File: rtl/la_serial_port.sv
// Config frame shifter and bit-serial readout sequencer.
module la_serial_port #(
    parameter int W     = 128,
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int HDR_W = 16,
    parameter int CFG_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rise_i,
    input  logic             cfg_bit_i,
    input  logic [HDR_W-1:0] hdr_i,
    input  logic [AW-1:0]    start_i,
    input  logic [W-1:0]     rdata_i,
    output logic             arm_o,
    output logic             arm_mode_o,
    output logic [AW-1:0]    arm_pos_o,
    output logic [AW-1:0]    raddr_o,
    output logic             sdo_o
);
    localparam int          CW    = $clog2(CFG_W);
    localparam int          MAXW  = (W > HDR_W) ? W : HDR_W;
    localparam int          BW    = $clog2(MAXW);
    localparam logic [AW:0] LASTW = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [CFG_W-1:0] cfg_sh;
        logic [CW-1:0]    cfg_cnt;
        logic [AW:0]      word;
        logic [BW-1:0]    bitn;
        logic [HDR_W-1:0] hdr;
        logic             sdo;
    } ser_t;

    ser_t q, d;
    logic [CFG_W-1:0] shifted;
    logic             arm;
    logic [HDR_W-1:0] hdr_sh;
    logic [W-1:0]     dat_sh;
    logic [AW:0]      word_m1;

    always_comb begin
        d       = q;
        arm     = 1'b0;
        shifted = {q.cfg_sh[CFG_W-2:0], cfg_bit_i};
        hdr_sh  = q.hdr >> q.bitn;
        dat_sh  = rdata_i >> q.bitn;
        word_m1 = q.word - 1'b1;
        if (rise_i) begin
            d.cfg_sh = shifted;
            if (q.cfg_cnt == CW'(CFG_W - 1)) begin
                d.cfg_cnt = '0;
                arm       = shifted[CFG_W-1];
            end else begin
                d.cfg_cnt = q.cfg_cnt + 1'b1;
            end
            if (q.word == '0) begin
                if (q.bitn == BW'(HDR_W - 1)) d.hdr = hdr_i;
                if (q.bitn == '0) begin
                    if (q.hdr[HDR_W-1]) begin
                        d.word = (AW+1)'(1);
                        d.bitn = BW'(W - 1);
                    end else begin
                        d.bitn = BW'(HDR_W - 1);
                    end
                end else begin
                    d.bitn = q.bitn - 1'b1;
                end
            end else if (q.bitn == '0) begin
                if (q.word == LASTW) begin
                    d.word = '0;
                    d.bitn = BW'(HDR_W - 1);
                end else begin
                    d.word = q.word + 1'b1;
                    d.bitn = BW'(W - 1);
                end
            end else begin
                d.bitn = q.bitn - 1'b1;
            end
            if (arm) begin
                d.word = '0;
                d.bitn = BW'(HDR_W - 1);
            end
        end
        if (q.word == '0)
            d.sdo = (q.bitn == BW'(HDR_W - 1)) ? hdr_i[HDR_W-1] : hdr_sh[0];
        else
            d.sdo = dat_sh[0];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q      <= '0;
            q.bitn <= BW'(HDR_W - 1);
        end else begin
            q <= d;
        end
    end

    assign arm_o      = arm;
    assign arm_mode_o = shifted[CFG_W-2];
    assign arm_pos_o  = shifted[AW-1:0];
    assign raddr_o    = start_i + word_m1[AW-1:0];
    assign sdo_o      = q.sdo;
endmodule

// File: rtl/trig_logic_analyzer.sv
module trig_logic_analyzer #(
    parameter int W     = 128,
    parameter int DEPTH = 64
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] probe_i,
    input  logic         trig_i,
    input  logic         sw_clk_i,
    input  logic         cfg_sdi_i,
    output logic         sdo_o
);
    localparam int AW    = $clog2(DEPTH);
    localparam int HDR_W = la_pkg::hdr_width(AW);
    localparam int CFG_W = AW + 2;

    logic             rise, cfg_bit;
    logic             arm, arm_mode;
    logic [AW-1:0]    arm_pos;
    logic             we;
    logic [AW-1:0]    waddr, start, raddr;
    logic [HDR_W-1:0] hdr;
    logic             done, busy;
    logic [AW:0]      valid;
    logic [W-1:0]     rdata;

    la_sync_edge u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sclk_i (sw_clk_i),
        .sdi_i  (cfg_sdi_i),
        .rise_o (rise),
        .sdi_o  (cfg_bit)
    );

    la_capture_ctrl #(.DEPTH(DEPTH), .AW(AW), .HDR_W(HDR_W)) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .trig_i     (trig_i),
        .arm_i      (arm),
        .arm_mode_i (arm_mode),
        .arm_pos_i  (arm_pos),
        .we_o       (we),
        .waddr_o    (waddr),
        .start_o    (start),
        .hdr_o      (hdr),
        .done_o     (done),
        .busy_o     (busy),
        .valid_o    (valid)
    );

    la_sample_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk_i   (clk_i),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (probe_i),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    la_serial_port #(.W(W), .DEPTH(DEPTH), .AW(AW), .HDR_W(HDR_W), .CFG_W(CFG_W)) u_ser (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rise_i     (rise),
        .cfg_bit_i  (cfg_bit),
        .hdr_i      (hdr),
        .start_i    (start),
        .rdata_i    (rdata),
        .arm_o      (arm),
        .arm_mode_o (arm_mode),
        .arm_pos_o  (arm_pos),
        .raddr_o    (raddr),
        .sdo_o      (sdo_o)
    );
endmodule

// File: rtl/la_checker.sv
module la_checker #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          arm_i,
    input logic          we_i,
    input logic          done_i,
    input logic          busy_i,
    input logic [AW:0]   valid_i,
    input logic [AW-1:0] waddr_i
);
    AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_i && busy_i)); // R8

    AST_FROZEN_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> !we_i); // R11

    AST_VALID_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i <= (AW+1)'(DEPTH)); // R6

    AST_ARM_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> (busy_i && !done_i)); // R2

    AST_WRITE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && $past(we_i)) |-> (waddr_i == AW'($past(waddr_i) + 1'b1))); // R1
endmodule

bind trig_logic_analyzer la_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm),
    .we_i    (we),
    .done_i  (done),
    .busy_i  (busy),
    .valid_i (valid),
    .waddr_i (waddr)
);

// File: tb/sim_trig_logic_analyzer.sv
`timescale 1ns/1ps
module sim_trig_logic_analyzer;
    localparam int W = 16;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] probe = '0;
    logic trig = 1'b0;
    logic sw = 1'b0;
    logic sdi = 1'b0;
    logic sdo;
    logic [31:0] cyc = '0;
    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) probe <= cyc[W-1:0];

    trig_logic_analyzer #(.W(W), .DEPTH(DEPTH)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .probe_i(probe), .trig_i(trig),
        .sw_clk_i(sw), .cfg_sdi_i(sdi), .sdo_o(sdo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] hdr_exp(input logic dn, input logic bz,
                                            input logic [6:0] vc, input logic md,
                                            input logic [5:0] ps);
        return {dn, bz, vc, md, ps};
    endfunction

    task automatic sw_bit(input logic din, output logic dout);
        dout = sdo;
        sdi = din;
        repeat (5) @(negedge clk);
        sw = 1'b1;
        repeat (5) @(negedge clk);
        sw = 1'b0;
    endtask

    task automatic send_cfg(input logic a, input logic m, input logic [5:0] p);
        logic [7:0] w;
        logic dummy;
        w = {a, m, p};
        for (int i = 7; i >= 0; i--) sw_bit(w[i], dummy);
    endtask

    task automatic read_n(output logic [15:0] v);
        logic b;
        for (int i = 15; i >= 0; i--) begin
            sw_bit(1'b0, b);
            v[i] = b;
        end
    endtask

    task automatic pulse_trig(output logic [31:0] tc);
        @(negedge clk);
        trig = 1'b1;
        tc = cyc;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic triggered(input logic [5:0] pos, input string tag, input bit recheck);
        logic [15:0] h, wv;
        logic [31:0] tc;
        send_cfg(1'b1, 1'b0, pos);
        repeat (20) @(negedge clk);
        read_n(h);
        chk({"R2 armed header ", tag}, h, hdr_exp(1'b0, 1'b1, 7'd0, 1'b0, pos));
        repeat (80) @(negedge clk);
        pulse_trig(tc);
        repeat (100) @(negedge clk);
        read_n(h);
        chk({"R8 done header ", tag}, h, hdr_exp(1'b1, 1'b0, 7'd64, 1'b0, pos));
        for (int k = 0; k < DEPTH; k++) begin
            read_n(wv);
            chk({tag, " sample"}, wv, 16'(tc - pos + k));
        end
        read_n(h);
        chk("R9 wrap to header", h, hdr_exp(1'b1, 1'b0, 7'd64, 1'b0, pos));
        if (recheck) begin
            repeat (60) @(negedge clk);
            read_n(wv);
            chk("R11 frozen first entry", wv, 16'(tc - pos));
        end
    endtask

    initial begin
        logic [15:0] h, wv, base;
        logic [5:0] p;
        int unsigned rnd;
        rnd = $urandom(32'd7331);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10 reset sdo", {31'd0, sdo}, 32'd0);
        read_n(h);
        chk("R10 reset header", h, 16'h0000);

        send_cfg(1'b0, 1'b1, 6'd5);
        send_cfg(1'b0, 1'b0, 6'd9);
        repeat (20) @(negedge clk);
        read_n(h);
        chk("R3 arm=0 frame ignored", h, 16'h0000);

        triggered(6'd0, "R5 pos0", 1'b0);
        triggered(6'd63, "R5 pos63", 1'b0);
        for (int i = 0; i < 3; i++) begin
            p = 6'($urandom_range(62, 1));
            triggered(p, "R4 R1 random", (i == 0));
        end

        // early trigger: held high across the arm frame
        p = 6'($urandom_range(50, 10));
        trig = 1'b1;
        send_cfg(1'b1, 1'b0, p);
        repeat (100) @(negedge clk);
        trig = 1'b0;
        read_n(h);
        chk("R6 early header", h, hdr_exp(1'b1, 1'b0, 7'(64 - p), 1'b0, p));
        base = '0;
        for (int k = 0; k < DEPTH; k++) begin
            read_n(wv);
            if (k == p) base = wv;
            if (k > p) chk("R6 consecutive after trigger", wv, 16'(base + (k - p)));
        end

        // continuous mode, trigger pulses must not matter
        send_cfg(1'b1, 1'b1, 6'd20);
        repeat (10) @(negedge clk);
        trig = 1'b1;
        repeat (3) @(negedge clk);
        trig = 1'b0;
        repeat (100) @(negedge clk);
        read_n(h);
        chk("R7 continuous header", h, hdr_exp(1'b1, 1'b0, 7'd64, 1'b1, 6'd20));
        base = '0;
        for (int k = 0; k < DEPTH; k++) begin
            read_n(wv);
            if (k == 0) base = wv;
            else chk("R7 continuous consecutive", wv, 16'(base + k));
        end
        read_n(h);
        chk("R9 wrap after continuous", h, hdr_exp(1'b1, 1'b0, 7'd64, 1'b1, 6'd20));

        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule